// File: doc/BRIEF.md
# Key-Tweaked AES-128 Block Encryptor

This core encrypts one 128-bit block under a 128-bit key using the AES-128 round structure, except that every byte substitution uses the standard S-box output XORed with a single modifier byte derived from the key. Each round runs in one clock cycle. A block starts when the start strobe is seen while the core is idle. Ten clocks later the ciphertext appears on a registered output, together with a one-cycle completion pulse.

A one-bit mode input is sampled at start and chooses how the modifier is formed. Mode 0 takes the leading key byte. Mode 1 takes the XOR of all sixteen key bytes. The same modified table serves the state rounds and the on-the-fly round-key schedule. A modifier of zero gives standard AES-128.

Top module: `tweak_aes_enc`

## Requirements
- R1: A start accepted while idle makes done_o rise exactly 10 clock cycles later, with ct_o valid in that same cycle.
- R2: done_o is high for exactly one cycle per block.
- R3: A start strobe while a block is in progress is ignored: the running block's result and timing are unchanged and no extra block follows.
- R4: With mode_i=0 the modifier is key byte 0 (key_i[127:120]); with mode_i=1 it is the XOR of all sixteen key bytes. Both are sampled at start.
- R5: With a modifier of 00 the output equals standard AES-128 (key 000102..0f, plaintext 00112233..ff gives 69c4e0d86a7b0430d8cdb78070b4c55a).
- R6: Each substitution, in the state rounds and in the round-key schedule, returns the standard S-box value XORed with the modifier.
- R7: ct_o holds its value from one done_o pulse until the next, including while a new block runs.
- R8: After synchronous reset done_o is 0 and ct_o is all zeros.
- R9: Byte k of a 128-bit word sits at bits [127-8k -: 8] and fills the state column by column (column k/4, row k%4). The last of the 10 rounds skips column mixing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a block when idle |
| mode_i | input | 1 | Modifier source: 0 leading key byte, 1 XOR of all key bytes |
| pt_i | input | 128 | Plaintext block |
| key_i | input | 128 | Cipher key |
| ct_o | output | 128 | Ciphertext, registered |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a start strobe that arrives mid-block with different plaintext, key and mode. Because the core takes no back-pressure, a second start can only reach the core by firing it a few cycles after the first. The bench does this and checks that the latency, the single done pulse and the ciphertext all belong to the first block. It also uses a key whose leading byte differs from the XOR of all its bytes, so that the two modes give different ciphertexts.

// File: rtl/tweak_aes_pkg.sv
package tweak_aes_pkg;

  typedef logic [7:0] byte_t;

  function automatic byte_t xt(input byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gmul(input byte_t a, input byte_t b);
    byte_t acc;
    byte_t sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = xt(sh);
    end
    return acc;
  endfunction

  // Multiplicative inverse as x^254, then the affine map.
  function automatic byte_t sbox_std(input byte_t x);
    byte_t sq;
    byte_t inv;
    sq  = x;
    inv = 8'h01;
    for (int i = 0; i < 7; i++) begin
      sq  = gmul(sq, sq);
      inv = gmul(inv, sq);
    end
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
           {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

endpackage

// File: rtl/tweak_sub_lanes.sv
module tweak_sub_lanes
  import tweak_aes_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [8*LANES-1:0] din,
  input  logic [7:0]         tweak,
  output logic [8*LANES-1:0] dout
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dout[8*g +: 8] = sbox_std(din[8*g +: 8]) ^ tweak;
  end
endmodule

// File: rtl/tweak_mod_select.sv
module tweak_mod_select #(
  parameter int KBYTES = 16
) (
  input  logic [8*KBYTES-1:0] key,
  input  logic                mode,
  output logic [7:0]          tweak
);
  logic [7:0] fold;
  always_comb begin
    fold = 8'h00;
    for (int i = 0; i < KBYTES; i++) fold = fold ^ key[8*i +: 8];
  end
  assign tweak = mode ? fold : key[8*KBYTES-1 -: 8];
endmodule

// File: rtl/tweak_key_step.sv
module tweak_key_step #(
  parameter int W = 128
) (
  input  logic [W-1:0] rk_cur,
  input  logic [7:0]   rcon,
  input  logic [7:0]   tweak,
  output logic [W-1:0] rk_next
);
  logic [31:0] w0, w1, w2, w3, rot, subw, tmp;
  logic [31:0] n0, n1, n2, n3;

  assign {w0, w1, w2, w3} = rk_cur;
  assign rot = {w3[23:0], w3[31:24]};

  tweak_sub_lanes #(.LANES(4)) u_sub (
    .din  (rot),
    .tweak(tweak),
    .dout (subw)
  );

  assign tmp = subw ^ {rcon, 24'h0};
  assign n0  = w0 ^ tmp;
  assign n1  = w1 ^ n0;
  assign n2  = w2 ^ n1;
  assign n3  = w3 ^ n2;
  assign rk_next = {n0, n1, n2, n3};
endmodule

// File: rtl/tweak_round_fn.sv
module tweak_round_fn
  import tweak_aes_pkg::*;
#(
  parameter int NB = 16
) (
  input  logic [8*NB-1:0] st_in,
  input  logic [8*NB-1:0] rk,
  input  logic [7:0]      tweak,
  input  logic            last,
  output logic [8*NB-1:0] st_out
);
  localparam int W    = 8 * NB;
  localparam int COLS = NB / 4;

  logic [W-1:0] sb, sr, mc;

  tweak_sub_lanes #(.LANES(NB)) u_sub (
    .din  (st_in),
    .tweak(tweak),
    .dout (sb)
  );

  for (genvar c = 0; c < COLS; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      assign sr[W-1-8*(4*c+r) -: 8] = sb[W-1-8*(4*((c+r)%COLS)+r) -: 8];
    end
    logic [7:0] a0, a1, a2, a3;
    assign a0 = sr[W-1-8*(4*c)   -: 8];
    assign a1 = sr[W-1-8*(4*c+1) -: 8];
    assign a2 = sr[W-1-8*(4*c+2) -: 8];
    assign a3 = sr[W-1-8*(4*c+3) -: 8];
    assign mc[W-1-8*(4*c)   -: 8] = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
    assign mc[W-1-8*(4*c+1) -: 8] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
    assign mc[W-1-8*(4*c+2) -: 8] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
    assign mc[W-1-8*(4*c+3) -: 8] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
  end

  assign st_out = (last ? sr : mc) ^ rk;
endmodule

// File: rtl/tweak_aes_enc.sv
module tweak_aes_enc
  import tweak_aes_pkg::*;
#(
  parameter int BLK    = 128,
  parameter int ROUNDS = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic           mode_i,
  input  logic [127:0]   pt_i,
  input  logic [127:0]   key_i,
  output logic [127:0]   ct_o,
  output logic           done_o
);
  localparam int NB = BLK / 8;
  localparam int RW = $clog2(ROUNDS + 1);

  logic           busy_q;
  logic [RW-1:0]  round_q;
  logic [BLK-1:0] state_q, rk_q, rk_nx, state_nx;
  logic [7:0]     rcon_q, tweak_q, tweak_in;
  logic           last_rnd;

  tweak_mod_select #(.KBYTES(NB)) u_mod (
    .key  (key_i),
    .mode (mode_i),
    .tweak(tweak_in)
  );

  tweak_key_step #(.W(BLK)) u_key (
    .rk_cur (rk_q),
    .rcon   (rcon_q),
    .tweak  (tweak_q),
    .rk_next(rk_nx)
  );

  assign last_rnd = (round_q == RW'(ROUNDS));

  tweak_round_fn #(.NB(NB)) u_rnd (
    .st_in (state_q),
    .rk    (rk_nx),
    .tweak (tweak_q),
    .last  (last_rnd),
    .st_out(state_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      round_q <= '0;
      state_q <= '0;
      rk_q    <= '0;
      rcon_q  <= 8'h00;
      tweak_q <= 8'h00;
      ct_o    <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          state_q <= pt_i ^ key_i;
          rk_q    <= key_i;
          rcon_q  <= 8'h01;
          tweak_q <= tweak_in;
          round_q <= RW'(1);
          busy_q  <= 1'b1;
        end
      end else begin
        state_q <= state_nx;
        rk_q    <= rk_nx;
        rcon_q  <= xt(rcon_q);
        if (last_rnd) begin
          busy_q  <= 1'b0;
          round_q <= '0;
          ct_o    <= state_nx;
          done_o  <= 1'b1;
        end else begin
          round_q <= round_q + RW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/tweak_aes_enc_chk.sv
module tweak_aes_enc_chk #(
  parameter int ROUNDS = 10,
  parameter int RW     = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic          done_o,
  input logic [127:0]  ct_o,
  input logic          busy_q,
  input logic [RW-1:0] round_q
);
  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && start_i) |=> (busy_q && round_q == RW'(1)));             // R1
  AST_LAST_GIVES_DONE: assert property (@(posedge clk) disable iff (rst)
    (busy_q && round_q == RW'(ROUNDS)) |=> (done_o && !busy_q));         // R1
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);                                                 // R2
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start_i && round_q != RW'(ROUNDS))
      |=> (busy_q && round_q == $past(round_q) + RW'(1)));               // R3
  AST_CT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(ct_o));                                          // R7
endmodule

bind tweak_aes_enc tweak_aes_enc_chk #(.ROUNDS(ROUNDS), .RW(RW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start_i(start_i),
  .done_o (done_o),
  .ct_o   (ct_o),
  .busy_q (busy_q),
  .round_q(round_q)
);

// File: tb/tweak_aes_enc_tb_top.sv
module tweak_aes_enc_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic         mode_i = 1'b0;
  logic [127:0] pt_i = '0;
  logic [127:0] key_i = '0;
  logic [127:0] ct_o;
  logic         done_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] tbl [256];

  always #5 clk = ~clk;

  tweak_aes_enc dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
    .pt_i(pt_i), .key_i(key_i), .ct_o(ct_o), .done_o(done_o)
  );

  // ---------------- reference model ----------------
  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p = 16'h0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011b << (i - 8));
    return p[7:0];
  endfunction

  task automatic build_table();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv = 8'h00;
      logic [7:0] s;
      for (int y = 1; y < 256; y++)
        if (m_mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      s = 8'h63;
      for (int b = 0; b < 8; b++)
        s[b] = s[b] ^ inv[b] ^ inv[(b+4)%8] ^ inv[(b+5)%8] ^ inv[(b+6)%8] ^ inv[(b+7)%8];
      tbl[x] = s;
    end
  endtask

  function automatic logic [127:0] model(input logic [127:0] pt, input logic [127:0] key,
                                         input logic [7:0] tw);
    logic [7:0] s[16], t[16], k[16];
    logic [7:0] rc = 8'h01;
    logic [127:0] res;
    for (int i = 0; i < 16; i++) begin
      k[i] = key[127-8*i -: 8];
      s[i] = pt[127-8*i -: 8] ^ k[i];
    end
    for (int r = 1; r <= 10; r++) begin
      logic [7:0] g[4];
      g[0] = tbl[k[13]] ^ tw ^ rc; g[1] = tbl[k[14]] ^ tw;
      g[2] = tbl[k[15]] ^ tw;      g[3] = tbl[k[12]] ^ tw;
      for (int i = 0; i < 16; i++)
        k[i] = k[i] ^ ((i < 4) ? g[i] : k[i-4]);
      rc = m_mul(rc, 8'h02);
      for (int i = 0; i < 16; i++) s[i] = tbl[s[i]] ^ tw;
      for (int c = 0; c < 4; c++)
        for (int rw = 0; rw < 4; rw++) t[4*c+rw] = s[4*((c+rw)%4)+rw];
      for (int c = 0; c < 4; c++)
        for (int rw = 0; rw < 4; rw++)
          s[4*c+rw] = (r == 10) ? t[4*c+rw] :
            m_mul(t[4*c+rw], 8'h02) ^ m_mul(t[4*c+(rw+1)%4], 8'h03) ^
            t[4*c+(rw+2)%4] ^ t[4*c+(rw+3)%4];
      for (int i = 0; i < 16; i++) s[i] = s[i] ^ k[i];
    end
    for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
    return res;
  endfunction

  function automatic logic [7:0] fold_key(input logic [127:0] key);
    logic [7:0] f = 8'h00;
    for (int i = 0; i < 16; i++) f = f ^ key[8*i +: 8];
    return f;
  endfunction

  // ---------------- helpers ----------------
  task automatic check(input string req, input string what,
                       input logic [127:0] got, input logic [127:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  // Starts a block, returns cycles to done and the ciphertext.
  task automatic run_block(input logic [127:0] pt, input logic [127:0] key, input logic md,
                           output int lat, output logic [127:0] ct);
    @(negedge clk);
    pt_i = pt; key_i = key; mode_i = md; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    ct = ct_o;
  endtask

  localparam logic [127:0] K1 = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] P1 = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] C1 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] K2 = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] P2 = 128'h3243f6a8885a308d313198a2e0370734;

  task automatic t_reset();
    check("R8", "done after reset", 128'(done_o), 128'h0);
    check("R8", "ct after reset", ct_o, 128'h0);
  endtask

  task automatic t_standard();
    int lat; logic [127:0] ct;
    run_block(P1, K1, 1'b0, lat, ct);
    check("R5", "zero-modifier vector mode0", ct, C1);
    check("R9", "column-major byte order", ct, C1);
    check("R1", "latency", 128'(lat), 128'd10);
    @(negedge clk);
    check("R2", "done drops after one cycle", 128'(done_o), 128'h0);
    run_block(P1, K1, 1'b1, lat, ct);
    check("R5", "zero-modifier vector mode1", ct, C1);
  endtask

  task automatic t_tweaked();
    int lat; logic [127:0] ct;
    run_block(P2, K2, 1'b0, lat, ct);
    check("R6", "mode0 tweak 2b vs model", ct, model(P2, K2, K2[127:120]));
    check("R4", "mode0 differs from mode1 model", 128'(ct != model(P2, K2, fold_key(K2))), 128'h1);
    run_block(P2, K2, 1'b1, lat, ct);
    check("R4", "mode1 folded tweak vs model", ct, model(P2, K2, fold_key(K2)));
    run_block(~P1, K2 ^ K1, 1'b0, lat, ct);
    check("R6", "second tweak pattern vs model", ct, model(~P1, K2 ^ K1, K2[127:120] ^ K1[127:120]));
  endtask

  task automatic t_busy_start();
    int lat = 0; int pulses = 0;
    logic [127:0] old_ct, exp_ct;
    exp_ct = model(P2, K2, fold_key(K2));
    @(negedge clk);
    old_ct = ct_o;
    pt_i = P2; key_i = K2; mode_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 1; i <= 12; i++) begin
      if (i == 3) begin
        pt_i = P1; key_i = K1; mode_i = 1'b0; start_i = 1'b1;
      end
      if (i == 4) start_i = 1'b0;
      if (i == 5) check("R7", "ct holds during new block", ct_o, old_ct);
      @(negedge clk);
      if (done_o) begin
        pulses++;
        if (lat == 0) lat = i;
        check("R3", "result of first block kept", ct_o, exp_ct);
      end
    end
    check("R3", "latency unchanged by mid-run start", 128'(lat), 128'd10);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (done_o) pulses++;
    end
    check("R3", "no extra block started", 128'(pulses), 128'd1);
    check("R7", "ct holds after done", ct_o, exp_ct);
  endtask

  initial begin
    #2000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    build_table();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_standard();
    t_tweaked();
    t_busy_start();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule